// File: doc/BRIEF.md
# Multi-Slope Integrating Converter Sequencer

This block is the digital side of an integrating analog-to-digital converter. A start request begins a conversion. The block first connects the input to the integrator for a fixed number of clock cycles. It then discharges the integrator through a series of reference sources, each weaker than the one before. A single comparator watches the integrator output. When the comparator output changes level, the current phase ends and the next phase begins. The next phase runs in the opposite direction, so that it removes the overshoot left by the phase before it. Each phase has its own counter. When the last phase ends, the counts are merged into one weighted code, and a one-cycle strobe marks the code as valid.

A parameter selects between two variants. The subranging variant has three run-down phases with sources weighted 1, 1/16 and 1/256, and a 4-bit counter for each phase. The classic dual-slope variant has one run-down phase with a single wide counter. The comparator reaches the block through a two-flop synchroniser. The block subtracts the delay this adds, so each count equals the number of source cycles up to and including the cycle in which the comparator changed.

Top module: `slope_adc_seq`

## Requirements
- R1: While reset is held and right after it is released, `int_en`, `src_en`, `rd_dir`, `code`, `ovr` and `done` are all zero.
- R2: A start request seen in idle raises `int_en` from the next cycle. `int_en` stays high for exactly `INT_CYC` cycles, and `src_en[0]` follows in the very next cycle.
- R3: The run-down sources are enabled one at a time, in order from index 0 upward, with no idle cycle between them. `rd_dir` is 0 on even phase indices and 1 on odd ones, and at most one of `int_en`/`src_en` is high in any cycle.
- R4: The comparator may change level in either direction. A phase whose raw comparator changes during its d-th enabled cycle keeps its source on for d+2 cycles. It ends at the clock edge where the synchronised level change is first seen, and it records a count of d.
- R5: In the subranging variant, `code` = N0·256 + N1·16 + N2, where Nk is the count of phase index k. This is three 4-bit fields with phase 0 in bits [11:8] and phase 2 in bits [3:0].
- R6: `done` is high for exactly one cycle, in the first cycle after the last source turns off. `code` and `ovr` take their new values in that same cycle and hold them until the next `done`.
- R7: A phase with no comparator change within its first 2^W−1 enabled cycles (W being the per-phase counter width) ends after 2^W+1 enabled cycles. It records 2^W−1 and makes `ovr` read 1 with that result. A change in exactly cycle 2^W−1 records 2^W−1 with `ovr` 0.
- R8: A start request while a conversion is in progress has no effect. The phase lengths, the result and the return to idle are the same as without it.
- R9: A start request in the same cycle as `done` is accepted: `int_en` rises in the following cycle.
- R10: In the dual-slope variant there is one run-down phase whose counter is `DUAL_W` bits wide. `code` equals that count, which is full scale times run-down count over integration count when `INT_CYC` = 2^`DUAL_W`. R4, R6 and R7 apply to it with W = `DUAL_W`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion request, sampled in idle only |
| cmp_in | input | 1 | Raw comparator level from the integrator |
| int_en | output | 1 | Connects the input to the integrator |
| src_en | output | NPH (3 subranging, 1 dual) | One enable per run-down source, index 0 strongest |
| rd_dir | output | 1 | Run-down polarity for the active source |
| code | output | NPH·CW (12 subranging) | Weighted conversion result |
| ovr | output | 1 | Some phase saturated in the last conversion |
| done | output | 1 | One-cycle result-valid strobe |

## Verification
Two events can land in the same cycle. The first is the result strobe together with a new start request. The bench raises `start` during the `done` cycle and expects the integration window to open one cycle later, with full length and a fresh result. The second is a comparator change in the last countable cycle of a phase, which is also the cycle where saturation would begin. The bench places the change in cycle 15 of a 4-bit phase and requires a count of 15 with `ovr` clear. A change that never comes must give the same count with `ovr` set.

// File: rtl/slope_adc_pkg.sv
package slope_adc_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_INTEG = 2'd1,
        SEQ_RUNDN = 2'd2
    } seq_st_e;

endpackage

// File: rtl/slope_sync.sv
module slope_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic chg
);
    // STAGES synchronising flops plus one history flop
    logic [STAGES:0] chain_q, chain_d;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    // level change seen at the synchronised output
    assign chg = chain_q[STAGES-1] ^ chain_q[STAGES];

endmodule

// File: rtl/slope_ph_cnt.sv
module slope_ph_cnt #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)     cnt_d = '0;
        else if (en) cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr) |=> (cnt_q == $past(cnt_q) + W'(1)));

endmodule

// File: rtl/slope_code_mix.sv
module slope_code_mix #(
    parameter int NPH   = 3,
    parameter int CW    = 4,
    parameter int OUT_W = NPH * CW
) (
    input  logic [NPH*CW-1:0] cnts,
    output logic [OUT_W-1:0]  code
);
    logic [OUT_W-1:0] acc [NPH+1];

    assign acc[0] = '0;

    // phase k carries weight 2^(CW*(NPH-1-k)): phase 0 is most significant
    for (genvar k = 0; k < NPH; k++) begin : g_term
        logic [OUT_W-1:0] term;
        assign term       = OUT_W'(cnts[k*CW +: CW]) << (CW * (NPH - 1 - k));
        assign acc[k + 1] = acc[k] + term;
    end

    assign code = acc[NPH];

endmodule

// File: rtl/slope_adc_seq.sv
module slope_adc_seq
    import slope_adc_pkg::*;
#(
    parameter int SUBRANGE = 1,
    parameter int SUB_W    = 4,
    parameter int DUAL_W   = 10,
    parameter int INT_CYC  = 256,
    parameter int SYNC_N   = 2,
    localparam int NPH     = (SUBRANGE != 0) ? 3 : 1,
    localparam int CW      = (SUBRANGE != 0) ? SUB_W : DUAL_W,
    localparam int OUT_W   = NPH * CW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cmp_in,
    output logic             int_en,
    output logic [NPH-1:0]   src_en,
    output logic             rd_dir,
    output logic [OUT_W-1:0] code,
    output logic             ovr,
    output logic             done
);
    localparam int MAXC = (1 << CW) - 1;
    localparam int LIM  = MAXC + SYNC_N;
    localparam int RCW  = $clog2(LIM + 1);
    localparam int ICW  = (INT_CYC > 1) ? $clog2(INT_CYC) : 1;
    localparam int PHW  = (NPH > 1) ? $clog2(NPH) : 1;

    typedef struct packed {
        seq_st_e                st;
        logic [PHW-1:0]         ph;
        logic [ICW-1:0]         icnt;
        logic [NPH-1:0][CW-1:0] cnts;
        logic                   ovr_acc;
        logic                   ovr;
        logic                   done;
        logic [OUT_W-1:0]       code;
    } seq_t;

    seq_t r_q, r_d;

    logic                   chg;
    logic [RCW-1:0]         run_cnt;
    logic                   ph_clr, ph_en;
    logic                   ph_end;
    logic [CW-1:0]          rec;
    logic [RCW:0]           elapsed;
    logic [NPH-1:0][CW-1:0] cnts_nx;
    logic [OUT_W-1:0]       code_nx;

    slope_sync #(.STAGES(SYNC_N)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (cmp_in),
        .chg   (chg)
    );

    slope_ph_cnt #(.W(RCW)) u_rcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ph_clr),
        .en    (ph_en),
        .cnt   (run_cnt)
    );

    // phase end detection and latency-compensated count
    always_comb begin
        ph_end  = (r_q.st == SEQ_RUNDN) && (chg || (run_cnt == RCW'(LIM - 1)));
        elapsed = {1'b0, run_cnt} + (RCW + 1)'(1);
        rec     = CW'(MAXC);
        if (chg) begin
            if (elapsed <= (RCW + 1)'(SYNC_N))
                rec = '0;
            else if ((elapsed - (RCW + 1)'(SYNC_N)) < (RCW + 1)'(MAXC))
                rec = CW'(elapsed - (RCW + 1)'(SYNC_N));
        end
        cnts_nx = r_q.cnts;
        for (int k = 0; k < NPH; k++) begin
            if (ph_end && (r_q.ph == PHW'(k))) cnts_nx[k] = rec;
        end
    end

    slope_code_mix #(.NPH(NPH), .CW(CW), .OUT_W(OUT_W)) u_mix (
        .cnts (cnts_nx),
        .code (code_nx)
    );

    // next-state logic
    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        ph_clr   = 1'b0;
        ph_en    = (r_q.st == SEQ_RUNDN);
        unique case (r_q.st)
            SEQ_IDLE: begin
                if (start) begin
                    r_d.st      = SEQ_INTEG;
                    r_d.icnt    = '0;
                    r_d.cnts    = '0;
                    r_d.ovr_acc = 1'b0;
                end
            end
            SEQ_INTEG: begin
                if (r_q.icnt == ICW'(INT_CYC - 1)) begin
                    r_d.st = SEQ_RUNDN;
                    r_d.ph = '0;
                    ph_clr = 1'b1;
                end else begin
                    r_d.icnt = r_q.icnt + ICW'(1);
                end
            end
            SEQ_RUNDN: begin
                if (ph_end) begin
                    ph_clr   = 1'b1;
                    r_d.cnts = cnts_nx;
                    if (!chg) r_d.ovr_acc = 1'b1;
                    if (r_q.ph == PHW'(NPH - 1)) begin
                        r_d.st   = SEQ_IDLE;
                        r_d.ph   = '0;
                        r_d.done = 1'b1;
                        r_d.code = code_nx;
                        r_d.ovr  = r_q.ovr_acc | ~chg;
                    end else begin
                        r_d.ph = r_q.ph + PHW'(1);
                    end
                end
            end
            default: r_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign int_en = (r_q.st == SEQ_INTEG);
    assign rd_dir = (r_q.st == SEQ_RUNDN) & r_q.ph[0];
    assign code   = r_q.code;
    assign ovr    = r_q.ovr;
    assign done   = r_q.done;

    for (genvar k = 0; k < NPH; k++) begin : g_src
        assign src_en[k] = (r_q.st == SEQ_RUNDN) && (r_q.ph == PHW'(k));
    end

    // R3
    src_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({int_en, src_en}));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(src_en[NPH-1]));

    // R8
    integ_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_en) |-> $past(r_q.st == SEQ_IDLE));

    // R4
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == SEQ_RUNDN) && !chg && (run_cnt != RCW'(LIM - 1)))
        |=> ((r_q.st == SEQ_RUNDN) && $stable(src_en)));

endmodule

// File: tb/slope_adc_seq_bench.sv
module slope_adc_seq_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic cmp = 1'b0;
    logic start2 = 1'b0;
    logic cmp2 = 1'b0;

    logic        int_en, rd_dir, ovr, done;
    logic [2:0]  src_en;
    logic [11:0] code;

    logic        int_en2, rd_dir2, ovr2, done2;
    logic [0:0]  src_en2;
    logic [5:0]  code2;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    slope_adc_seq #(.SUBRANGE(1), .SUB_W(4), .INT_CYC(64)) u_slope_adc_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .cmp_in(cmp),
        .int_en(int_en), .src_en(src_en), .rd_dir(rd_dir),
        .code(code), .ovr(ovr), .done(done)
    );

    slope_adc_seq #(.SUBRANGE(0), .DUAL_W(6), .INT_CYC(64)) u_slope_adc_seq_dual (
        .clk(clk), .rst_n(rst_n), .start(start2), .cmp_in(cmp2),
        .int_en(int_en2), .src_en(src_en2), .rd_dir(rd_dir2),
        .code(code2), .ovr(ovr2), .done(done2)
    );

    // d0, d1, d2 (raw comparator change cycle per phase, 99 = never), code, ovr
    localparam int TBL [8][5] = '{
        '{ 1,  1,  1,  273, 0},
        '{15, 15, 15, 4095, 0},
        '{ 5, 10,  3, 1443, 0},
        '{ 8,  1, 12, 2076, 0},
        '{ 2, 14,  7,  743, 0},
        '{20,  3,  4, 3892, 1},
        '{ 6, 99,  9, 1785, 1},
        '{ 3,  7, 99,  895, 1}
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic sub_conv(input int d0, input int d1, input int d2,
                            input int exp_code, input int exp_ovr,
                            input bit pre, input bit poke, input bit chain);
        int d [3];
        int cyc;
        int nexp;
        logic [11:0] held;
        d[0] = d0; d[1] = d1; d[2] = d2;
        if (!pre) begin
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        cyc = 0;
        while (int_en === 1'b1 && cyc < 1000) begin
            cyc++;
            @(negedge clk);
        end
        check("R2 integration length", cyc, 64);
        for (int k = 0; k < 3; k++) begin
            check("R3 source order", int'(src_en), 1 << k);
            check("R3 run-down direction", int'(rd_dir), k % 2);
            cyc = 0;
            while (src_en[k] === 1'b1 && cyc < 100) begin
                cyc++;
                if (cyc == d[k]) cmp = ~cmp;
                if (poke && k == 1) start = (cyc == 2);
                @(negedge clk);
            end
            start = 1'b0;
            nexp = (d[k] <= 15) ? d[k] + 2 : 17;
            if (d[k] <= 15) check("R4 phase source cycles", cyc, nexp);
            else            check("R7 saturated phase cycles", cyc, nexp);
        end
        check("R6 done after last phase", int'(done), 1);
        check("R6 sources off at done", int'(src_en), 0);
        check("R5 weighted code", int'(code), exp_code);
        check("R7 overrange flag", int'(ovr), exp_ovr);
        held = code;
        if (chain) begin
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check("R6 done one cycle", int'(done), 0);
            check("R9 restart in done cycle", int'(int_en), 1);
        end else begin
            @(negedge clk);
            check("R6 done one cycle", int'(done), 0);
            check("R8 idle after conversion", int'(int_en), 0);
            check("R6 code held", int'(code), int'(held));
        end
    endtask

    task automatic dual_conv(input int d, input int exp_code, input int exp_ovr);
        int cyc;
        start2 = 1'b1;
        @(negedge clk);
        start2 = 1'b0;
        cyc = 0;
        while (int_en2 === 1'b1 && cyc < 1000) begin
            cyc++;
            @(negedge clk);
        end
        check("R10 dual integration length", cyc, 64);
        check("R10 dual source on", int'(src_en2), 1);
        cyc = 0;
        while (src_en2[0] === 1'b1 && cyc < 200) begin
            cyc++;
            if (cyc == d) cmp2 = ~cmp2;
            @(negedge clk);
        end
        check("R10 dual phase cycles", cyc, (d <= 63) ? d + 2 : 65);
        check("R10 dual done", int'(done2), 1);
        check("R10 dual code", int'(code2), exp_code);
        check("R10 dual overrange", int'(ovr2), exp_ovr);
        @(negedge clk);
        check("R10 dual done one cycle", int'(done2), 0);
    endtask

    task automatic report();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            report();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        check("R1 int_en in reset", int'(int_en), 0);
        check("R1 src_en in reset", int'(src_en), 0);
        check("R1 code in reset", int'(code), 0);
        check("R1 done in reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ovr after reset", int'(ovr), 0);
        check("R1 rd_dir after reset", int'(rd_dir), 0);
        check("R1 int_en after reset", int'(int_en), 0);
        repeat (2) @(negedge clk);

        // table of vectors: R4, R5, R7
        for (int i = 0; i < 8; i++) begin
            sub_conv(TBL[i][0], TBL[i][1], TBL[i][2], TBL[i][3], TBL[i][4], 1'b0, 1'b0, 1'b0);
            repeat (3) @(negedge clk);
        end

        // R8: start pulse in the middle of phase 1 has no effect
        sub_conv(4, 4, 4, 1092, 0, 1'b0, 1'b1, 1'b0);
        repeat (5) @(negedge clk);
        check("R8 still idle after busy start", int'(int_en) | int'(src_en), 0);

        // R9: start arrives together with done
        sub_conv(2, 3, 4, 564, 0, 1'b0, 1'b0, 1'b1);
        sub_conv(9, 9, 9, 2457, 0, 1'b1, 1'b0, 1'b0);
        repeat (3) @(negedge clk);

        // R10: dual-slope variant, including limit and saturation
        dual_conv(40, 40, 0);
        dual_conv(1, 1, 0);
        dual_conv(63, 63, 0);
        dual_conv(99, 63, 1);

        finished = 1;
        report();
        $finish;
    end

endmodule